// File: doc/BRIEF.md
# Transceiver Fault Interrupt Register

This block collects single-cycle fault strobes from the safety monitors around a CAN transceiver and holds each one as a sticky flag in a small set of byte-wide detail registers. Each detail register feeds one group bit of a summary byte. One global bit in that summary byte is set whenever any detail flag is set. While that global bit is set, an active-low interrupt line is held low toward the host.

The host reads any register through a combinational read port. It clears flags by writing ones to the bit positions it has serviced. The summary byte is derived and cannot be written. Addresses outside the register window read as zero.

Register layout: summary at 0x50; the TXD timeout detail at 0x51; thermal and supply detail at 0x52; SPI, inactivity and memory-check detail at 0x53; bus fault detail at 0x54.

Top module: `fint_ctrl`

## Requirements
- R1: After reset, whether at start-up or mid-run, every register reads 0x00 and `irq_n` is 1.
- R2: A strobe on `ev_thermal` sets 0x52 bit 1. Strobes on `ev_uv_vcc`, `ev_uv_vio` and `ev_uv_vsup` set 0x52 bits 2, 3 and 4. Any set bit in 0x52 sets summary bit 5 of 0x50.
- R3: A strobe on `ev_txd_tmo` sets 0x51 bit 0. A set bit in 0x51 sets summary bit 6 of 0x50.
- R4: A strobe on `ev_spi_err` sets 0x53 bit 7, `ev_inactive` sets 0x53 bit 5, and `ev_crc_fail` sets 0x53 bit 0. Any set bit in 0x53 sets summary bit 4 of 0x50.
- R5: Each bit k of `ev_bus` (k = 0..6) sets 0x54 bit k. Any set bit in 0x54 sets summary bit 3 of 0x50.
- R6: Summary bit 7 of 0x50 is 1 exactly when at least one detail bit in 0x51 to 0x54 is 1.
- R7: Detail bits are sticky. A detail bit is cleared only by a write of 1 to that bit position at its own address. A 0 in the write data, or a write to another address, leaves the bit unchanged.
- R8: If a strobe and a clearing write hit the same detail bit in one cycle, the bit ends up set.
- R9: `irq_n` is 0 while any detail bit is set. It returns to 1 in the cycle after the clock edge that takes the write clearing the last set bit.
- R10: Reads of any address other than 0x50 to 0x54 return 0x00. Writes to 0x50 or to unmapped addresses change nothing. Detail bit positions with no source always read 0.
- R11: A flag set by a strobe is visible on `rd_data` and `irq_n` from the first clock edge at which the strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_thermal | input | 1 | Over-temperature strobe |
| ev_uv_vcc | input | 1 | Transceiver supply undervoltage strobe |
| ev_uv_vio | input | 1 | I/O supply undervoltage strobe |
| ev_uv_vsup | input | 1 | Battery supply undervoltage strobe |
| ev_txd_tmo | input | 1 | Transmit-input stuck-dominant timeout strobe |
| ev_spi_err | input | 1 | Serial frame clock-count error strobe |
| ev_inactive | input | 1 | Inactivity timer expiry strobe |
| ev_crc_fail | input | 1 | Configuration memory check failure strobe |
| ev_bus | input | 7 | Bus fault strobes, one per fault kind |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data; ones select the bits to clear |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data for `rd_addr` |
| irq_n | output | 1 | Interrupt to host, active low |

## Verification
A monitor strobe and a host clearing write can land on the same detail bit in the same cycle. The bench provokes this by driving `ev_thermal` together with a write of 0x02 to 0x52 in one cycle, and also `ev_spi_err` together with a write of 0x80 to 0x53. It then reads the registers and `irq_n` after that edge and requires the bit still set and the interrupt still asserted. A second overlap is a clear of the last flag at the same edge where the interrupt is sampled. For that case the bench checks `irq_n` low before the edge and high after it.

// File: rtl/fint_pkg.sv
// Package: shared layout constants for the fault interrupt register.
// Assumes a byte-wide register file with one summary byte and a fixed
// set of detail bytes, each owning one group bit in the summary.
package fint_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int NUM_DET = 4;
    localparam int BUS_W   = 7;

    localparam logic [ADDR_W-1:0] SUM_ADDR = 8'h50;
    localparam int GLOBAL_BIT = 7;

    // Index 0..3 -> 0x51 (txd), 0x52 (supply/thermal), 0x53 (host link), 0x54 (bus)
    localparam logic [NUM_DET-1:0][ADDR_W-1:0] DET_ADDR = {8'h54, 8'h53, 8'h52, 8'h51};
    localparam logic [NUM_DET-1:0][DATA_W-1:0] DET_MASK = {8'h7F, 8'hA1, 8'h1E, 8'h01};
    localparam int DET_GRP [NUM_DET] = '{6, 5, 4, 3};

    localparam int IDX_TXD  = 0;
    localparam int IDX_PWR  = 1;
    localparam int IDX_LINK = 2;
    localparam int IDX_BUS  = 3;

    localparam int B_TXD   = 0;
    localparam int B_THERM = 1;
    localparam int B_UVCC  = 2;
    localparam int B_UVIO  = 3;
    localparam int B_UVSUP = 4;
    localparam int B_SPI   = 7;
    localparam int B_INACT = 5;
    localparam int B_CRC   = 0;
endpackage

// File: rtl/fint_sticky_reg.sv
// Module: one byte of sticky detail flags with write-one-to-clear.
// Assumes set strobes are one cycle wide; a set beats a clear of the
// same bit in the same cycle; bits outside VALID never become 1.
module fint_sticky_reg #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0,
    parameter logic [DATA_W-1:0] VALID    = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q_o
);
    logic [DATA_W-1:0] clr_mask;

    // Select which bits the host is clearing this cycle.
    always_comb begin
        clr_mask = (wr_en && wr_addr == REG_ADDR) ? wr_data : '0;
    end

    // Hold flags; clear on request, then apply new events on top.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= ((q_o & ~clr_mask) | set_i) & VALID;
    end
endmodule

// File: rtl/fint_summary.sv
// Module: derives the summary byte from the detail registers.
// Assumes each detail register maps to exactly one group bit and that
// the global bit is distinct from every group bit.
module fint_summary
    import fint_pkg::*;
(
    input  logic [NUM_DET-1:0][DATA_W-1:0] det_i,
    output logic [DATA_W-1:0]              sum_o
);
    // OR each detail byte into its group bit and all of them into the global bit.
    always_comb begin
        sum_o = '0;
        for (int i = 0; i < NUM_DET; i++) begin
            sum_o[DET_GRP[i]] = |det_i[i];
        end
        sum_o[GLOBAL_BIT] = |det_i;
    end
endmodule

// File: rtl/fint_rdmux.sv
// Module: read-only address decode over summary and detail bytes.
// Assumes addresses are unique; anything unmatched reads zero.
module fint_rdmux
    import fint_pkg::*;
(
    input  logic [ADDR_W-1:0]              rd_addr,
    input  logic [DATA_W-1:0]              sum_i,
    input  logic [NUM_DET-1:0][DATA_W-1:0] det_i,
    output logic [DATA_W-1:0]              rd_data
);
    // Pick the byte that lives at the requested address.
    always_comb begin
        rd_data = '0;
        if (rd_addr == SUM_ADDR) rd_data = sum_i;
        for (int i = 0; i < NUM_DET; i++) begin
            if (rd_addr == DET_ADDR[i]) rd_data = det_i[i];
        end
    end
endmodule

// File: rtl/fint_ctrl.sv
// Module: top of the fault interrupt register. Routes monitor strobes to
// their detail bits, builds the summary byte and drives the interrupt.
// Assumes all strobes are synchronous to clk and one cycle wide.
module fint_ctrl
    import fint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_thermal,
    input  logic              ev_uv_vcc,
    input  logic              ev_uv_vio,
    input  logic              ev_uv_vsup,
    input  logic              ev_txd_tmo,
    input  logic              ev_spi_err,
    input  logic              ev_inactive,
    input  logic              ev_crc_fail,
    input  logic [BUS_W-1:0]  ev_bus,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);
    logic [NUM_DET-1:0][DATA_W-1:0] set_vec;
    logic [NUM_DET-1:0][DATA_W-1:0] det_q;
    logic [DATA_W-1:0]              sum_w;

    // Map each monitor strobe onto its fixed detail bit.
    always_comb begin
        set_vec = '0;
        set_vec[IDX_TXD][B_TXD]    = ev_txd_tmo;
        set_vec[IDX_PWR][B_THERM]  = ev_thermal;
        set_vec[IDX_PWR][B_UVCC]   = ev_uv_vcc;
        set_vec[IDX_PWR][B_UVIO]   = ev_uv_vio;
        set_vec[IDX_PWR][B_UVSUP]  = ev_uv_vsup;
        set_vec[IDX_LINK][B_SPI]   = ev_spi_err;
        set_vec[IDX_LINK][B_INACT] = ev_inactive;
        set_vec[IDX_LINK][B_CRC]   = ev_crc_fail;
        set_vec[IDX_BUS][BUS_W-1:0] = ev_bus;
    end

    for (genvar g = 0; g < NUM_DET; g++) begin : g_det
        fint_sticky_reg #(
            .DATA_W  (DATA_W),
            .ADDR_W  (ADDR_W),
            .REG_ADDR(DET_ADDR[g]),
            .VALID   (DET_MASK[g])
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[g]),
            .wr_en  (wr_en),
            .wr_addr(wr_addr),
            .wr_data(wr_data),
            .q_o    (det_q[g])
        );
    end

    fint_summary u_sum (
        .det_i(det_q),
        .sum_o(sum_w)
    );

    fint_rdmux u_mux (
        .rd_addr(rd_addr),
        .sum_i  (sum_w),
        .det_i  (det_q),
        .rd_data(rd_data)
    );

    // Interrupt is asserted (low) while the global summary bit is set.
    always_comb begin
        irq_n = ~sum_w[GLOBAL_BIT];
    end
endmodule

// File: rtl/fint_ctrl_chk.sv
// Module: property checker for fint_ctrl, attached by bind.
// Assumes it sees the detail flop outputs of the top module.
module fint_ctrl_chk
    import fint_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          ev_thermal,
    input logic                          ev_txd_tmo,
    input logic                          ev_spi_err,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [DATA_W-1:0]             wr_data,
    input logic [ADDR_W-1:0]             rd_addr,
    input logic [DATA_W-1:0]             rd_data,
    input logic                          irq_n,
    input logic [NUM_DET-1:0][DATA_W-1:0] det_q
);
    a_r2_thermal_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_thermal |=> det_q[IDX_PWR][B_THERM]);

    a_r3_txd_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_txd_tmo |=> det_q[IDX_TXD][B_TXD]);

    a_r4_spi_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_spi_err |=> det_q[IDX_LINK][B_SPI]);

    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_spi_err && wr_en && wr_addr == DET_ADDR[IDX_LINK] && wr_data[B_SPI])
        |=> det_q[IDX_LINK][B_SPI]);

    a_r9_irq_tracks_flags: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == (det_q == '0));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr < SUM_ADDR || rd_addr > DET_ADDR[NUM_DET-1]) |-> rd_data == '0);

    for (genvar g = 0; g < NUM_DET; g++) begin : g_sticky
        a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == DET_ADDR[g])
            |=> ((det_q[g] & $past(det_q[g])) == $past(det_q[g])));
    end
endmodule

bind fint_ctrl fint_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_thermal(ev_thermal),
    .ev_txd_tmo(ev_txd_tmo),
    .ev_spi_err(ev_spi_err),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .irq_n     (irq_n),
    .det_q     (det_q)
);

// File: tb/fint_ctrl_bench.sv
// Bench: table-driven event mapping followed by directed corner tests.
module fint_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_thermal = 0, ev_uv_vcc = 0, ev_uv_vio = 0, ev_uv_vsup = 0;
    logic       ev_txd_tmo = 0, ev_spi_err = 0, ev_inactive = 0, ev_crc_fail = 0;
    logic [6:0] ev_bus = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fint_ctrl u_fint_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ev_thermal(ev_thermal), .ev_uv_vcc(ev_uv_vcc), .ev_uv_vio(ev_uv_vio),
        .ev_uv_vsup(ev_uv_vsup), .ev_txd_tmo(ev_txd_tmo), .ev_spi_err(ev_spi_err),
        .ev_inactive(ev_inactive), .ev_crc_fail(ev_crc_fail), .ev_bus(ev_bus),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
    );

    // Entry: {events[14:0], exp 0x50, 0x51, 0x52, 0x53, 0x54}
    // events bit: 0 thermal, 1 vcc, 2 vio, 3 vsup, 4 txd, 5 spi, 6 inact, 7 crc, 14:8 bus
    localparam int NV = 12;
    localparam logic [54:0] VEC [NV] = '{
        {15'h0001, 8'hA0, 8'h00, 8'h02, 8'h00, 8'h00},  // R2 thermal
        {15'h0002, 8'hA0, 8'h00, 8'h04, 8'h00, 8'h00},  // R2 vcc
        {15'h0004, 8'hA0, 8'h00, 8'h08, 8'h00, 8'h00},  // R2 vio
        {15'h0008, 8'hA0, 8'h00, 8'h10, 8'h00, 8'h00},  // R2 vsup
        {15'h0010, 8'hC0, 8'h01, 8'h00, 8'h00, 8'h00},  // R3 txd
        {15'h0020, 8'h90, 8'h00, 8'h00, 8'h80, 8'h00},  // R4 spi
        {15'h0040, 8'h90, 8'h00, 8'h00, 8'h20, 8'h00},  // R4 inactivity
        {15'h0080, 8'h90, 8'h00, 8'h00, 8'h01, 8'h00},  // R4 crc
        {15'h0100, 8'h88, 8'h00, 8'h00, 8'h00, 8'h01},  // R5 bus bit 0
        {15'h7F00, 8'h88, 8'h00, 8'h00, 8'h00, 8'h7F},  // R5 all bus bits
        {15'h0831, 8'hF8, 8'h01, 8'h02, 8'h80, 8'h08},  // R6 mixed groups
        {15'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}   // R9 no event
    };
    localparam string VTAG [NV] = '{"R2", "R2", "R2", "R2", "R3", "R4", "R4", "R4",
                                    "R5", "R5", "R6", "R11"};

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic drive_ev(input logic [14:0] e);
        ev_thermal = e[0]; ev_uv_vcc = e[1]; ev_uv_vio = e[2]; ev_uv_vsup = e[3];
        ev_txd_tmo = e[4]; ev_spi_err = e[5]; ev_inactive = e[6]; ev_crc_fail = e[7];
        ev_bus = e[14:8];
    endtask

    task automatic pulse(input logic [14:0] e);
        @(negedge clk); drive_ev(e);
        @(negedge clk); drive_ev('0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic clear_all();
        for (int a = 8'h51; a <= 8'h54; a++) wr(8'(a), 8'hFF);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R1: start-up reset state
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 8'h50; a <= 8'h54; a++) chk_reg("R1", 8'(a), 8'h00);
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);

        // Table walk: R2..R6, R11 mapping and one-cycle visibility, R9 release
        for (int k = 0; k < NV; k++) begin
            pulse(VEC[k][54:40]);
            chk_reg(VTAG[k], 8'h50, VEC[k][39:32]);
            chk_reg(VTAG[k], 8'h51, VEC[k][31:24]);
            chk_reg(VTAG[k], 8'h52, VEC[k][23:16]);
            chk_reg(VTAG[k], 8'h53, VEC[k][15:8]);
            chk_reg(VTAG[k], 8'h54, VEC[k][7:0]);
            chk("R9 irq_n with flags", {7'b0, irq_n}, (VEC[k][39:32] == 0) ? 8'h01 : 8'h00);
            clear_all();
            chk("R9 irq_n after clear", {7'b0, irq_n}, 8'h01);
        end

        // R7: zeros in write data and other addresses do not clear
        pulse(15'h0001);
        wr(8'h52, 8'hFD);
        chk_reg("R7 zero bit kept", 8'h52, 8'h02);
        wr(8'h51, 8'hFF);
        wr(8'h53, 8'hFF);
        chk_reg("R7 other addr kept", 8'h52, 8'h02);
        // R10: write to summary and unmapped addresses ignored
        wr(8'h50, 8'hFF);
        wr(8'h60, 8'hFF);
        chk_reg("R10 summary write", 8'h50, 8'hA0);
        chk_reg("R10 detail intact", 8'h52, 8'h02);
        chk_reg("R10 unmapped 4F", 8'h4F, 8'h00);
        chk_reg("R10 unmapped 55", 8'h55, 8'h00);
        chk_reg("R10 unmapped 00", 8'h00, 8'h00);
        chk_reg("R10 unmapped FF", 8'hFF, 8'h00);
        wr(8'h52, 8'h02);
        chk_reg("R7 one clears", 8'h52, 8'h00);

        // R10: unused positions stay zero with every source firing
        pulse(15'h7FFF);
        chk_reg("R10 unused 51", 8'h51, 8'h01);
        chk_reg("R10 unused 52", 8'h52, 8'h1E);
        chk_reg("R10 unused 53", 8'h53, 8'hA1);
        chk_reg("R10 unused 54", 8'h54, 8'h7F);
        clear_all();

        // R8: set and clear of the same bit in one cycle
        @(negedge clk);
        drive_ev(15'h0021); wr_en = 1'b1; wr_addr = 8'h52; wr_data = 8'h02;
        @(negedge clk);
        drive_ev('0); wr_en = 1'b0;
        chk_reg("R8 thermal set wins", 8'h52, 8'h02);
        @(negedge clk);
        drive_ev(15'h0020); wr_en = 1'b1; wr_addr = 8'h53; wr_data = 8'h80;
        @(negedge clk);
        drive_ev('0); wr_en = 1'b0;
        chk_reg("R8 spi set wins", 8'h53, 8'h80);
        chk("R8 irq_n held", {7'b0, irq_n}, 8'h00);

        // R9: interrupt held until the last flag clears, then released next cycle
        wr(8'h52, 8'h02);
        chk("R9 one flag left", {7'b0, irq_n}, 8'h00);
        @(negedge clk); wr_en = 1'b1; wr_addr = 8'h53; wr_data = 8'hFF;
        #1;
        chk("R9 before edge", {7'b0, irq_n}, 8'h00);
        @(negedge clk); wr_en = 1'b0;
        chk("R9 after edge", {7'b0, irq_n}, 8'h01);

        // R1: mid-run reset clears everything
        pulse(15'h7FFF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int a = 8'h50; a <= 8'h54; a++) chk_reg("R1 mid-run", 8'(a), 8'h00);
        chk("R1 irq_n mid-run", {7'b0, irq_n}, 8'h01);
        rd(8'h50, d);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule